// File: doc/BRIEF.md
# Synchronous FIFO with Programmable Almost-Empty and Almost-Full Flags

This block is a single-clock first-in first-out buffer built over a block of on-chip memory. The data width and the number of entries are parameters, matching whichever aspect ratio of the memory is chosen. The block keeps its own write and read address counters and an occupancy counter. From the occupancy it produces four registered status flags: empty, full, and two early-warning flags whose trip levels come in on input ports and may change while the buffer is running.

A producer raises `push` with `push_data`. A consumer raises `pop` and picks up `pop_data` on the cycle after the edge that accepted the pop. Requests that cannot be served are dropped without any side effect: a push into a full buffer, or a pop from an empty one. The early-warning levels let a producer throttle before the buffer fills, or let a consumer start a burst only once enough data is queued.

Top module: `levelflag_fifo`

## Requirements
- R1: While `rst_n` is low at a clock edge, that edge clears both address counters and the occupancy, sets `is_empty` and `near_empty` to 1, and sets `is_full` and `near_full` to 0.
- R2: Accepted items leave in the order they were accepted. `pop_data` shows the item on the cycle after the edge that accepted the pop, and it holds that value until the next accepted pop.
- R3: A push while the occupancy equals DEPTH (and no pop is accepted at the same edge) is dropped. The occupancy stays at DEPTH, and the dropped word is never returned by a later pop.
- R4: A pop while the occupancy is 0 is dropped. `is_empty` stays 1, and `pop_data` keeps its previous value.
- R5: After each edge, `is_empty` is 1 exactly when the occupancy is 0.
- R6: After each edge, `is_full` is 1 exactly when the occupancy equals DEPTH.
- R7: After each edge, `near_empty` is 1 exactly when the occupancy is less than or equal to `empty_level`. The comparison uses the value of `empty_level` at that edge.
- R8: After each edge, `near_full` is 1 exactly when the occupancy is greater than or equal to `full_level`. The comparison uses the value of `full_level` at that edge.
- R9: When both requests are made at one edge:
  - if the buffer is neither empty nor full, both are accepted and the occupancy is unchanged;
  - if the buffer is empty, only the push is accepted;
  - if the buffer is full, only the pop is accepted.
- R10: A change of `empty_level` or `full_level` updates the near flags at the next edge, even when no push or pop happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| push | input | 1 | Write request |
| push_data | input | DATA_W | Word to store |
| pop | input | 1 | Read request |
| empty_level | input | CNT_W | Trip level for `near_empty` (occupancy at or below) |
| full_level | input | CNT_W | Trip level for `near_full` (occupancy at or above) |
| pop_data | output | DATA_W | Registered word returned by the last accepted pop |
| is_empty | output | 1 | Occupancy is zero |
| is_full | output | 1 | Occupancy equals DEPTH |
| near_empty | output | 1 | Occupancy at or below `empty_level` |
| near_full | output | 1 | Occupancy at or above `full_level` |

## Verification
A wrong occupancy shows on the flags at the very next edge: `is_empty` or `is_full` disagrees with the number of items held, or a near flag trips one item early or late. A pointer that slips or wraps wrongly leaves the flags correct but shows up in `pop_data`. There it appears as a repeated, skipped or stale word on the first pop that reaches the damaged slot, which can be up to DEPTH pops later. The bench therefore compares every flag after every edge against a queue model. It also compares every returned word in order, driving fills past full, drains past empty, and changes of the trip levels while the buffer is idle.

// File: rtl/levelflag_fifo_pkg.sv
// Package: shared types for the level-flagged FIFO.
// Assumes: nothing beyond IEEE 1800-2017.
package levelflag_fifo_pkg;

    // Registered status bundle produced by the flag stage.
    typedef struct packed {
        logic empty;
        logic near_empty;
        logic full;
        logic near_full;
    } fifo_status_t;

    // Status value forced by reset.
    localparam fifo_status_t STATUS_AT_RESET = '{empty: 1'b1, near_empty: 1'b1,
                                                 full: 1'b0, near_full: 1'b0};

endpackage

// File: rtl/lf_fifo_ptrs.sv
// Module: lf_fifo_ptrs
// Keeps the write pointer, the read pointer and the occupancy counter.
// It decides which requests are accepted and presents the occupancy the
// next edge will hold.
// Assumes: DEPTH >= 2; the pointers wrap at DEPTH, which need not be a power of two.
module lf_fifo_ptrs #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH),
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    output logic              wr_fire,
    output logic              rd_fire,
    output logic [ADDR_W-1:0] wr_ptr,
    output logic [ADDR_W-1:0] rd_ptr,
    output logic [CNT_W-1:0]  occupancy,
    output logic [CNT_W-1:0]  occupancy_nxt
);

    localparam logic [CNT_W-1:0]  CNT_FULL = CNT_W'(DEPTH);
    localparam logic [ADDR_W-1:0] PTR_LAST = ADDR_W'(DEPTH - 1);

    // Purpose: accept requests only when the buffer can serve them.
    always_comb begin
        wr_fire = push && (occupancy != CNT_FULL);
        rd_fire = pop  && (occupancy != '0);
    end

    // Purpose: form the occupancy that the next edge will hold.
    always_comb begin
        occupancy_nxt = occupancy;
        if (wr_fire && !rd_fire) begin
            occupancy_nxt = occupancy + CNT_W'(1);
        end else if (rd_fire && !wr_fire) begin
            occupancy_nxt = occupancy - CNT_W'(1);
        end
    end

    // Purpose: advance the pointers with wrap at DEPTH, and store the occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr    <= '0;
            rd_ptr    <= '0;
            occupancy <= '0;
        end else begin
            if (wr_fire) begin
                wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + ADDR_W'(1);
            end
            if (rd_fire) begin
                rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + ADDR_W'(1);
            end
            occupancy <= occupancy_nxt;
        end
    end

endmodule

// File: rtl/lf_fifo_store.sv
// Module: lf_fifo_store
// The storage array of DEPTH words, with one write port and one read port.
// The read word is registered and holds its value between accepted reads.
// Assumes: the controller never reads and writes the same slot at one edge.
// A full buffer blocks writes, so this cannot happen.
module lf_fifo_store #(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_fire,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_word,
    input  logic              rd_fire,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_word
);

    logic [DATA_W-1:0] cells [DEPTH];

    // Purpose: write an accepted word into its slot (storage has no reset).
    always_ff @(posedge clk) begin
        if (wr_fire) begin
            cells[wr_addr] <= wr_word;
        end
    end

    // Purpose: register the word at the read address when a read is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_word <= '0;
        end else if (rd_fire) begin
            rd_word <= cells[rd_addr];
        end
    end

endmodule

// File: rtl/lf_fifo_flags.sv
// Module: lf_fifo_flags
// Registers the four status flags from the occupancy the next edge will hold.
// The near flags compare against the trip levels as they stand at that edge.
// Assumes: the trip levels are in the range 0..DEPTH; any wider value still compares cleanly.
module lf_fifo_flags
    import levelflag_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] occupancy_nxt,
    input  logic [CNT_W-1:0] empty_level,
    input  logic [CNT_W-1:0] full_level,
    output fifo_status_t     status
);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    fifo_status_t status_nxt;

    // Purpose: decode the next occupancy into flag values.
    always_comb begin
        status_nxt.empty      = (occupancy_nxt == '0);
        status_nxt.near_empty = (occupancy_nxt <= empty_level);
        status_nxt.full       = (occupancy_nxt == CNT_FULL);
        status_nxt.near_full  = (occupancy_nxt >= full_level);
    end

    // Purpose: register the flags, forcing their reset values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= STATUS_AT_RESET;
        end else begin
            status <= status_nxt;
        end
    end

endmodule

// File: rtl/levelflag_fifo.sv
// Module: levelflag_fifo (top)
// A single-clock FIFO with empty, full and run-time programmable near-empty
// and near-full flags. It is built from a pointer/occupancy unit, a storage
// array and a registered flag stage.
// Assumes: one clock; synchronous active-low reset; DATA_W and DEPTH are chosen
// to suit the memory aspect ratio in use.
module levelflag_fifo
    import levelflag_fifo_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH),
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    input  logic [CNT_W-1:0]  empty_level,
    input  logic [CNT_W-1:0]  full_level,
    output logic [DATA_W-1:0] pop_data,
    output logic              is_empty,
    output logic              is_full,
    output logic              near_empty,
    output logic              near_full
);

    logic              wr_fire;
    logic              rd_fire;
    logic [ADDR_W-1:0] wr_ptr;
    logic [ADDR_W-1:0] rd_ptr;
    logic [CNT_W-1:0]  occupancy;
    logic [CNT_W-1:0]  occupancy_nxt;
    fifo_status_t      status;

    lf_fifo_ptrs #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ptrs (
        .clk           (clk),
        .rst_n         (rst_n),
        .push          (push),
        .pop           (pop),
        .wr_fire       (wr_fire),
        .rd_fire       (rd_fire),
        .wr_ptr        (wr_ptr),
        .rd_ptr        (rd_ptr),
        .occupancy     (occupancy),
        .occupancy_nxt (occupancy_nxt)
    );

    lf_fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_fire (wr_fire),
        .wr_addr (wr_ptr),
        .wr_word (push_data),
        .rd_fire (rd_fire),
        .rd_addr (rd_ptr),
        .rd_word (pop_data)
    );

    lf_fifo_flags #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_flags (
        .clk           (clk),
        .rst_n         (rst_n),
        .occupancy_nxt (occupancy_nxt),
        .empty_level   (empty_level),
        .full_level    (full_level),
        .status        (status)
    );

    // Purpose: present the registered flags at the ports.
    always_comb begin
        is_empty   = status.empty;
        near_empty = status.near_empty;
        is_full    = status.full;
        near_full  = status.near_full;
    end

endmodule

// File: rtl/levelflag_fifo_chk.sv
// Module: levelflag_fifo_chk
// Property checker for levelflag_fifo, attached through bind below.
// Assumes: it sees the top-level ports plus the stored occupancy register.
module levelflag_fifo_chk #(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 16,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              push,
    input logic              pop,
    input logic [CNT_W-1:0]  empty_level,
    input logic [CNT_W-1:0]  full_level,
    input logic [DATA_W-1:0] pop_data,
    input logic              is_empty,
    input logic              is_full,
    input logic              near_empty,
    input logic              near_full,
    input logic [CNT_W-1:0]  occupancy
);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    // R1: reset drives the flags to their reset values.
    assert_reset_flags_R1: assert property (@(posedge clk)
        !rst_n |=> (is_empty && near_empty && !is_full && !near_full));

    // R3: a lone push on a full buffer leaves it full.
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_full && push && !pop) |=> is_full);

    // R4: a lone pop on an empty buffer changes neither the flag nor the data.
    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_empty && pop && !push) |=> (is_empty && $stable(pop_data)));

    // R5: the empty flag agrees with the occupancy register.
    assert_empty_tracks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        is_empty == (occupancy == '0));

    // R6: the full flag agrees with the occupancy register.
    assert_full_tracks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        is_full == (occupancy == CNT_FULL));

    // R6: the occupancy never exceeds DEPTH.
    assert_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        occupancy <= CNT_FULL);

    // R7: near-empty compares against the level seen at the previous edge.
    assert_near_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (near_empty == (occupancy <= $past(empty_level))));

    // R8: near-full compares against the level seen at the previous edge.
    assert_near_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (near_full == (occupancy >= $past(full_level))));

    // R9: a push and a pop together on a partly filled buffer keep the occupancy.
    assert_both_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !is_empty && !is_full) |=> $stable(occupancy));

endmodule

bind levelflag_fifo levelflag_fifo_chk #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .CNT_W  (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .push        (push),
    .pop         (pop),
    .empty_level (empty_level),
    .full_level  (full_level),
    .pop_data    (pop_data),
    .is_empty    (is_empty),
    .is_full     (is_full),
    .near_empty  (near_empty),
    .near_full   (near_full),
    .occupancy   (occupancy)
);

// File: tb/levelflag_fifo_test.sv
// Scoreboard bench for levelflag_fifo.
// The driver applies requests at the falling edge and keeps a queue model.
// The monitor compares each returned word after the edge that accepted its pop.
module levelflag_fifo_test;

    localparam int DATA_W = 9;
    localparam int DEPTH  = 16;
    localparam int CNT_W  = $clog2(DEPTH + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              push = 1'b0;
    logic [DATA_W-1:0] push_data = '0;
    logic              pop = 1'b0;
    logic [CNT_W-1:0]  empty_level = CNT_W'(3);
    logic [CNT_W-1:0]  full_level = CNT_W'(13);
    logic [DATA_W-1:0] pop_data;
    logic              is_empty;
    logic              is_full;
    logic              near_empty;
    logic              near_full;

    int n_checks = 0;
    int n_fail   = 0;

    logic [DATA_W-1:0] model_q[$];
    logic [DATA_W-1:0] exp_q[$];
    logic              pop_expected = 1'b0;
    logic              mon_fire;

    levelflag_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .push        (push),
        .push_data   (push_data),
        .pop         (pop),
        .empty_level (empty_level),
        .full_level  (full_level),
        .pop_data    (pop_data),
        .is_empty    (is_empty),
        .is_full     (is_full),
        .near_empty  (near_empty),
        .near_full   (near_full)
    );

    // 200 MHz clock
    always #2.5 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Compare all four flags against the model occupancy and the current levels.
    task automatic check_flags();
        int c = model_q.size();
        chk("R5 is_empty", int'(is_empty), int'(c == 0));
        chk("R6 is_full", int'(is_full), int'(c == DEPTH));
        chk("R7 near_empty", int'(near_empty), int'(c <= int'(empty_level)));
        chk("R8 near_full", int'(near_full), int'(c >= int'(full_level)));
    endtask

    // Driver: one clock of requests; updates the model and the expected queue.
    task automatic step(input logic w, input logic r, input logic [DATA_W-1:0] d);
        logic w_ok;
        logic r_ok;
        @(negedge clk);
        push      = w;
        pop       = r;
        push_data = d;
        w_ok = w && (model_q.size() < DEPTH);
        r_ok = r && (model_q.size() > 0);
        if (r_ok) exp_q.push_back(model_q.pop_front());
        if (w_ok) model_q.push_back(d);
        pop_expected = r_ok;
        @(posedge clk);
        #1;
        push = 1'b0;
        pop  = 1'b0;
        pop_expected = 1'b0;
        check_flags();
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        push  = 1'b0;
        pop   = 1'b0;
        model_q.delete();
        exp_q.delete();
        repeat (2) @(posedge clk);
        #1;
        chk("R1 is_empty", int'(is_empty), 1);
        chk("R1 near_empty", int'(near_empty), 1);
        chk("R1 is_full", int'(is_full), 0);
        chk("R1 near_full", int'(near_full), 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Monitor: after each edge that accepted a pop, compare the returned word (R2).
    always @(posedge clk) begin
        mon_fire = pop_expected;
        #2;
        if (mon_fire) begin
            if (exp_q.size() == 0) begin
                chk("R2 unexpected pop data", int'(pop_data), -1);
            end else begin
                chk("R2 pop order", int'(pop_data), int'(exp_q.pop_front()));
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        apply_reset();

        // R4: a pop on an empty buffer is dropped; the data output holds 0.
        step(1'b0, 1'b1, '0);
        chk("R4 is_empty after pop on empty", int'(is_empty), 1);
        chk("R4 pop_data held", int'(pop_data), 0);

        // Fill to DEPTH; the flags are checked after each step (R5..R8).
        for (int i = 0; i < DEPTH; i++) begin
            step(1'b1, 1'b0, DATA_W'(i * 7 + 1));
        end
        chk("R6 full after fill", int'(is_full), 1);

        // R3: a push while full is dropped; 0x1AA must never come back.
        step(1'b1, 1'b0, DATA_W'(9'h1AA));
        chk("R3 still full", int'(is_full), 1);

        // R9: push and pop together while full, so only the pop is accepted.
        step(1'b1, 1'b1, DATA_W'(9'h155));
        chk("R9 full with both leaves one free", int'(is_full), 0);
        chk("R9 near_full at DEPTH-1", int'(near_full), 1);

        // R9: push and pop together when partly filled keep the occupancy.
        step(1'b1, 1'b1, DATA_W'(9'h0F0));
        chk("R9 occupancy held, not full", int'(is_full), 0);
        chk("R9 model occupancy", model_q.size(), DEPTH - 1);

        // Drain past empty; the order is checked by the monitor (R2, R3).
        for (int i = 0; i < DEPTH + 1; i++) begin
            step(1'b0, 1'b1, '0);
        end
        chk("R4 empty after drain", int'(is_empty), 1);

        // R10: with five items held, raising the empty level trips near_empty without traffic.
        for (int i = 0; i < 5; i++) begin
            step(1'b1, 1'b0, DATA_W'(9'h100 + i));
        end
        chk("R7 near_empty clear at 5 over level 3", int'(near_empty), 0);
        @(negedge clk);
        empty_level = CNT_W'(6);
        step(1'b0, 1'b0, '0);
        chk("R10 near_empty after level change", int'(near_empty), 1);
        @(negedge clk);
        full_level = CNT_W'(5);
        step(1'b0, 1'b0, '0);
        chk("R10 near_full after level change", int'(near_full), 1);

        // Drain, then push and pop together on an empty buffer (R9: only the push is accepted).
        for (int i = 0; i < 5; i++) begin
            step(1'b0, 1'b1, '0);
        end
        step(1'b1, 1'b1, DATA_W'(9'h033));
        chk("R9 empty with both stores one", int'(is_empty), 0);
        step(1'b0, 1'b1, '0);
        chk("R9 single item popped", int'(is_empty), 1);

        // R1: reset in mid-run with items held.
        empty_level = CNT_W'(3);
        full_level  = CNT_W'(13);
        step(1'b1, 1'b0, DATA_W'(9'h077));
        step(1'b1, 1'b0, DATA_W'(9'h078));
        apply_reset();
        step(1'b0, 1'b1, '0);
        chk("R1 buffer empty after reset", int'(is_empty), 1);
        step(1'b1, 1'b0, DATA_W'(9'h0AB));
        step(1'b0, 1'b1, '0);
        step(1'b0, 1'b0, '0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule